// File: doc/BRIEF.md
# Buck Converter Gate-Drive Sequencer

This block sequences the high-side and low-side gate drives of one synchronous buck stage. Each oscillator cycle starts with a one-cycle edge pulse. After a programmable dead time the high-side drive turns on. It turns off when the on-time comparator ends the pulse, when the current-limit flag fires, or when a maximum on-time counter expires. After a second dead time the low-side drive conducts. It stops at the next oscillator edge or when the inductor current reaches zero, so the low side acts as an emulated diode.

In light-load mode the high-side pulse ends on a low peak-current threshold rather than on the on-time comparator. While the output sits above regulation, whole oscillator cycles are skipped. All comparator flags come in already synchronised to `clk`. Dead time and maximum on-time are counted in `clk` cycles and set by the parameters `DEAD_CYC` and `MAX_ON_CYC`.

Top module: `buck_gate_timer`

## Requirements
- R1: While `rst_n` is low, and after reset until the first oscillator edge, `gate_hi` and `gate_lo` are both 0.
- R2: An `osc_edge` pulse sampled while both drives are idle raises `gate_hi` exactly `DEAD_CYC` clock cycles after the sampling edge.
- R3: In normal mode (`light_mode`=0) `gate_hi` stays high until `ton_done` is sampled, then falls at that edge; `gate_lo` rises exactly `DEAD_CYC` cycles later.
- R4: `gate_lo` falls at the edge that samples `izero` or `osc_edge`. When an edge ends the low side, `gate_hi` follows `DEAD_CYC` cycles after that edge.
- R5: `ilim`=1 forces `gate_hi` to 0 in the same cycle, with no clock edge needed. The high-side pulse then ends and `gate_lo` rises `DEAD_CYC` cycles after the edge that samples it. This applies on every cycle.
- R6: `gate_hi` is never high for more than `MAX_ON_CYC` consecutive cycles. With no terminating flag it is high for exactly `MAX_ON_CYC` cycles.
- R7: In light-load mode (`light_mode`=1) the high-side pulse ends on `light_thr`, and `ton_done` has no effect.
- R8: In light-load mode an `osc_edge` sampled with `out_high`=1 starts no pulse, and both drives stay 0. The first edge sampled with `out_high`=0 fires normally. In normal mode `out_high` is ignored.
- R9: `gate_hi` and `gate_lo` are never 1 together, and each rises only after at least `DEAD_CYC` cycles with both at 0.
- R10: `enable`=0 drives both outputs to 0 in the same cycle and returns the sequencer to idle. After re-enable, nothing fires until the next `osc_edge`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; 0 holds both drives off |
| osc_edge | input | 1 | One-cycle pulse marking the oscillator rising edge |
| light_mode | input | 1 | 1 selects light-load (pulse-skipping) operation |
| ton_done | input | 1 | On-time comparator tripped (normal mode) |
| ilim | input | 1 | Peak current limit flag |
| light_thr | input | 1 | Light-load peak current threshold reached |
| izero | input | 1 | Inductor current reached zero |
| out_high | input | 1 | Output is above regulation |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |

## Verification
The bench measures dead-time gaps in whole cycles on both transitions. A counter that is off by one would place the rising drive one cycle early or late.

It raises the current limit in the middle of a high-side pulse and samples before the next edge. A registered-only cutoff would leave `gate_hi` high for a cycle.

It sends oscillator edges while the low side conducts. Skipping the low-side turn-off or the dead-time wait would show up as overlap, or as a short gap before `gate_hi`.

It repeats edges with the output above regulation in both modes. A skip that leaked into normal mode, or a sequencer stuck in idle, would be visible. A long random run with current-limit, zero-current and enable glitches then checks overlap, gap length and pulse length on every cycle.

// File: rtl/bgt_pkg.sv
package bgt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_GAP_HI = 3'd1,
    PH_HIGH   = 3'd2,
    PH_GAP_LO = 3'd3,
    PH_LOW    = 3'd4
  } phase_e;

  // true on the last cycle of a window of lim cycles counted from zero
  function automatic logic count_reached(input int cnt, input int lim);
    return (cnt + 1) >= lim;
  endfunction

  // a pulse may start unless light-load mode sees the output above regulation
  function automatic logic fire_allowed(input logic light, input logic above);
    return !(light && above);
  endfunction

endpackage

// File: rtl/bgt_tick.sv
module bgt_tick #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (run && cnt != '1)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bgt_phase.sv
module bgt_phase
  import bgt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   osc_edge,
  input  logic   light_mode,
  input  logic   ton_done,
  input  logic   ilim,
  input  logic   light_thr,
  input  logic   izero,
  input  logic   out_high,
  input  logic   dead_done,
  input  logic   on_max,
  output phase_e phase,
  output logic   phase_chg
);
  phase_e nxt;
  logic   fire_ok;
  logic   hi_stop;

  assign fire_ok = fire_allowed(light_mode, out_high);
  assign hi_stop = ilim || on_max || (light_mode ? light_thr : ton_done);

  always_comb begin
    nxt = phase;
    if (!enable) begin
      nxt = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:   if (osc_edge && fire_ok) nxt = PH_GAP_HI;
        PH_GAP_HI: if (dead_done) nxt = PH_HIGH;
        PH_HIGH:   if (hi_stop) nxt = PH_GAP_LO;
        PH_GAP_LO: begin
          if (osc_edge && fire_ok) nxt = PH_GAP_HI;
          else if (dead_done)      nxt = PH_LOW;
        end
        PH_LOW: begin
          if (osc_edge && fire_ok)   nxt = PH_GAP_HI;
          else if (osc_edge || izero) nxt = PH_IDLE;
        end
        default: nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  assign phase_chg = (nxt != phase);
endmodule

// File: rtl/bgt_drive.sv
module bgt_drive
  import bgt_pkg::*;
(
  input  phase_e phase,
  input  logic   enable,
  input  logic   ilim,
  output logic   gate_hi,
  output logic   gate_lo
);
  // current limit and disable cut the drives without waiting for a clock edge
  assign gate_hi = enable && !ilim && (phase == PH_HIGH);
  assign gate_lo = enable && (phase == PH_LOW);
endmodule

// File: rtl/buck_gate_timer.sv
module buck_gate_timer
  import bgt_pkg::*;
#(
  parameter int DEAD_CYC   = 4,
  parameter int MAX_ON_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic osc_edge,
  input  logic light_mode,
  input  logic ton_done,
  input  logic ilim,
  input  logic light_thr,
  input  logic izero,
  input  logic out_high,
  output logic gate_hi,
  output logic gate_lo
);
  localparam int CNT_MAX = (MAX_ON_CYC > DEAD_CYC) ? MAX_ON_CYC : DEAD_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  phase_e        phase;
  logic          phase_chg;
  logic [CW-1:0] dead_cnt;
  logic [CW-1:0] on_cnt;
  logic          in_gap;
  logic          in_high;
  logic          dead_done;
  logic          on_max;

  assign in_gap    = (phase == PH_GAP_HI) || (phase == PH_GAP_LO);
  assign in_high   = (phase == PH_HIGH);
  assign dead_done = count_reached(32'(dead_cnt), DEAD_CYC);
  assign on_max    = count_reached(32'(on_cnt), MAX_ON_CYC);

  bgt_tick #(.W(CW)) u_dead (
    .clk(clk), .rst_n(rst_n), .clr(phase_chg), .run(in_gap), .cnt(dead_cnt)
  );

  bgt_tick #(.W(CW)) u_on (
    .clk(clk), .rst_n(rst_n), .clr(phase_chg), .run(in_high), .cnt(on_cnt)
  );

  bgt_phase u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .osc_edge(osc_edge),
    .light_mode(light_mode), .ton_done(ton_done), .ilim(ilim),
    .light_thr(light_thr), .izero(izero), .out_high(out_high),
    .dead_done(dead_done), .on_max(on_max), .phase(phase), .phase_chg(phase_chg)
  );

  bgt_drive u_drive (
    .phase(phase), .enable(enable), .ilim(ilim),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );
endmodule

// File: rtl/bgt_checker.sv
module bgt_checker #(
  parameter int DEAD_CYC   = 4,
  parameter int MAX_ON_CYC = 40
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic ilim,
  input logic gate_hi,
  input logic gate_lo
);
  localparam int GW = $clog2(DEAD_CYC + 1);
  localparam int RW = $clog2(MAX_ON_CYC + 2);
  localparam logic [GW-1:0] GAP_SAT = GW'(DEAD_CYC);
  localparam logic [RW-1:0] RUN_SAT = RW'(MAX_ON_CYC + 1);
  localparam logic [RW-1:0] RUN_LIM = RW'(MAX_ON_CYC);

  logic [GW-1:0] gap_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap_q <= GAP_SAT;
    else if (gate_hi || gate_lo) gap_q <= '0;
    else if (gap_q != GAP_SAT)   gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (!gate_hi)          run_q <= '0;
    else if (run_q != RUN_SAT)  run_q <= run_q + 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R9

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) || $rose(gate_lo)) |-> (gap_q >= GAP_SAT)); // R9

  AST_ON_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hi |-> (run_q < RUN_LIM)); // R6

  AST_ILIM_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    ilim |-> !gate_hi); // R5

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!gate_hi && !gate_lo)); // R10
endmodule

bind buck_gate_timer bgt_checker #(
  .DEAD_CYC(DEAD_CYC), .MAX_ON_CYC(MAX_ON_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ilim(ilim),
  .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/sim_buck_gate_timer.sv
module sim_buck_gate_timer;
  localparam int DEAD   = 4;
  localparam int MAXON  = 40;
  localparam int PERIOD = 44;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, enable, osc_edge, light_mode, ton_done, ilim, light_thr, izero, out_high;
  logic gate_hi, gate_lo;
  int   n_chk = 0;
  int   n_bad = 0;

  buck_gate_timer #(.DEAD_CYC(DEAD), .MAX_ON_CYC(MAXON)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .osc_edge(osc_edge),
    .light_mode(light_mode), .ton_done(ton_done), .ilim(ilim),
    .light_thr(light_thr), .izero(izero), .out_high(out_high),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  function automatic int exp_delay(input int dead);  return dead;  endfunction
  function automatic int exp_on_len(input int lim);  return lim;   endfunction
  function automatic bit gap_ok(input int gap, input int dead); return gap >= dead; endfunction
  function automatic bit may_fire(input bit light, input bit above); return !(light && above); endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_edge();
    osc_edge = 1'b1;
    @(negedge clk);
    osc_edge = 1'b0;
  endtask

  task automatic wait_hi(output int k);
    k = 0;
    while (gate_hi !== 1'b1 && k < 200) begin @(negedge clk); k++; end
  endtask

  task automatic wait_lo(output int k);
    k = 0;
    while (gate_lo !== 1'b1 && k < 200) begin @(negedge clk); k++; end
  endtask

  task automatic end_hi_pwm();
    ton_done = 1'b1; @(negedge clk); ton_done = 1'b0;
  endtask

  task automatic zero_cross();
    izero = 1'b1; @(negedge clk); izero = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    int len;
    rst_n = 0; enable = 0; osc_edge = 0; light_mode = 0; ton_done = 0;
    ilim = 0; light_thr = 0; izero = 0; out_high = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 in reset", {gate_hi, gate_lo}, 0);
    rst_n = 1; enable = 1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {gate_hi, gate_lo}, 0);

    // R2 / R3: normal cycle
    pulse_edge(); wait_hi(k);
    check("R2 high-side delay", k, exp_delay(DEAD));
    repeat (10) @(negedge clk);
    check("R3 high held", gate_hi, 1);
    end_hi_pwm();
    check("R3 high off at ton_done", gate_hi, 0);
    wait_lo(k);
    check("R3 low-side delay", k, exp_delay(DEAD));
    repeat (3) @(negedge clk);
    check("R4 low held", gate_lo, 1);
    zero_cross();
    check("R4 low off at zero current", gate_lo, 0);
    repeat (6) @(negedge clk);
    check("R4 stays idle", {gate_hi, gate_lo}, 0);

    // R4: edge while low side conducts
    pulse_edge(); wait_hi(k); end_hi_pwm(); wait_lo(k);
    pulse_edge();
    check("R4 low off at edge", gate_lo, 0);
    wait_hi(k);
    check("R4 high after edge gap", k, exp_delay(DEAD));

    // R5: current limit mid-pulse
    repeat (3) @(negedge clk);
    ilim = 1'b1; #1;
    check("R5 immediate cut", gate_hi, 0);
    @(negedge clk); ilim = 1'b0; #1;
    check("R5 pulse ended", gate_hi, 0);
    wait_lo(k);
    check("R5 low after limit", k, exp_delay(DEAD));
    zero_cross();

    // R6: maximum on-time
    pulse_edge(); wait_hi(k);
    len = 0;
    while (gate_hi === 1'b1 && len < 500) begin len++; @(negedge clk); end
    check("R6 max on length", len, exp_on_len(MAXON));
    wait_lo(k); zero_cross();

    // R7: light-load termination
    light_mode = 1; out_high = 0;
    pulse_edge(); wait_hi(k);
    ton_done = 1; repeat (3) @(negedge clk);
    check("R7 ton_done ignored", gate_hi, 1);
    ton_done = 0; light_thr = 1; @(negedge clk); light_thr = 0;
    check("R7 light threshold ends high", gate_hi, 0);
    wait_lo(k); zero_cross();

    // R8: skip while above regulation
    out_high = 1;
    for (int i = 0; i < 2; i++) begin
      pulse_edge();
      repeat (DEAD + 3) @(negedge clk);
      check("R8 edge skipped", {gate_hi, gate_lo}, may_fire(1, 1) ? 2 : 0);
    end
    out_high = 0;
    pulse_edge(); wait_hi(k);
    check("R8 fires after drop", k, exp_delay(DEAD));
    light_thr = 1; @(negedge clk); light_thr = 0;
    wait_lo(k); zero_cross();
    light_mode = 0; out_high = 1;
    pulse_edge(); wait_hi(k);
    check("R8 normal mode ignores out_high", k, exp_delay(DEAD));
    end_hi_pwm(); wait_lo(k); zero_cross(); out_high = 0;

    // R10: disable
    pulse_edge(); wait_hi(k);
    enable = 0; #1;
    check("R10 high cut on disable", gate_hi, 0);
    @(negedge clk); enable = 1;
    repeat (DEAD + 3) @(negedge clk);
    check("R10 idle after re-enable", {gate_hi, gate_lo}, 0);
    pulse_edge(); wait_hi(k);
    check("R10 restart delay", k, exp_delay(DEAD));
    end_hi_pwm(); wait_lo(k);
    enable = 0; #1;
    check("R10 low cut on disable", gate_lo, 0);
    @(negedge clk); enable = 1;
    repeat (3) @(negedge clk);

    // random run: R9 invariants plus R5, R6, R10
    begin
      int gap = 1000;
      int run = 0;
      bit pdh = 0, pdl = 0;
      for (int cyc = 0; cyc < 6000; cyc++) begin
        @(negedge clk);
        check("R9 no overlap", gate_hi & gate_lo, 0);
        if ((gate_hi && !pdh) || (gate_lo && !pdl))
          check("R9 dead gap", gap_ok(gap, DEAD), 1);
        if (!gate_hi && !gate_lo) gap++; else gap = 0;
        if (gate_hi) run++; else run = 0;
        if (run > MAXON) check("R6 run length", run, MAXON);
        if (!enable) check("R10 disabled off", {gate_hi, gate_lo}, 0);
        if (ilim)    check("R5 limit holds high off", gate_hi, 0);
        pdh = gate_hi; pdl = gate_lo;
        osc_edge  = (cyc % PERIOD) == 0;
        ton_done  = ($urandom % 8) == 0;
        ilim      = ($urandom % 40) == 0;
        light_thr = ($urandom % 6) == 0;
        izero     = ($urandom % 10) == 0;
        out_high  = ($urandom % 3) == 0;
        enable    = ($urandom % 150) != 0;
        if (($urandom % 300) == 0) light_mode = ~light_mode;
      end
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule